// File: doc/BRIEF.md
# Ready/Busy Status Unit

This unit watches the internal write/erase engine of one memory page and publishes its progress in two ways: three readable status bytes and one ready/busy output pin. The engine reports when an operation starts and when it completes (with its kind and a pass/fail flag). The command queue reports how many entries it holds. The sector buffer reports whether it has room. A lock checker reports when a request aimed at a locked block was refused. Configuration commands arrive as a strobe with a 3-bit code.

The pin has four behaviours. In level mode it shows busy as a low level. In the two pulse modes it gives a fixed-length low pulse when a write completes, or when an erase completes. In disabled mode it stays high. The compatible byte keeps a legacy single-register layout. The global byte adds queue, buffer, error summary and pin-mode fields. The block byte reports the lock bit and the failure flag of one selected block. Error flags are sticky until a clear-status command arrives.

Top module: `rb_status`

## Requirements
- R1: In level mode (code 0) `ry_by` is 0 while the engine is busy or `q_count` is nonzero, and 1 otherwise.
- R2: In pulse-on-write mode (code 1), a write completion (`op_done` with `op_erase`=0) drives `ry_by` low for exactly PULSE_LEN cycles, starting at the next clock edge. An erase completion gives no pulse. A write completion during a pulse restarts the full length.
- R3: In pulse-on-erase mode (code 2), an erase completion (`op_done` with `op_erase`=1) drives the same PULSE_LEN-cycle low pulse. Write completions give no pulse.
- R4: In disabled mode (code 3) `ry_by` is 1 whatever the engine and queue do.
- R5: With `cmd_stb` high, `cmd_op` codes 0 to 3 select the pin mode and code 4 clears the status flags. Codes 5 to 7 have no effect. A mode command cancels any pulse in progress and suppresses a pulse for a completion in the same cycle.
- R6: `csr` holds: bit 7 = engine idle, bit 5 = erase failure, bit 4 = write failure, bit 1 = locked-block refusal. All other bits read 0.
- R7: The failure and refusal flags are sticky and are cleared only by code 4. An event that arrives in the same cycle as the clear wins, so its flag stays set.
- R8: `gsr` holds: bit 7 = engine idle, bit 6 = queue full (`q_count` >= QDEPTH), bit 5 = queue nonempty, bit 3 = `buf_avail`, bit 2 = any error flag set, bits 1:0 = current pin-mode code. Bit 4 reads 0.
- R9: `bsr` holds for block `blk_sel`: bit 7 = engine idle, bit 6 = `blk_lock[blk_sel]`, bit 5 = a failure was reported for that block (`op_blk`) since the last clear. Bits 4:0 read 0.
- R10: While `rst_n` is low, all flags clear, the engine reads idle, any pulse stops and the pin mode returns to level.
- R11: `op_start` marks the engine busy from the next edge, and `op_done` marks it idle. When both arrive in the same cycle, the engine stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Engine begins an operation |
| op_done | input | 1 | Engine completes an operation |
| op_erase | input | 1 | Completion kind: 1 erase, 0 write |
| op_fail | input | 1 | Completing operation failed |
| op_blk | input | BW | Block of the completing operation |
| lock_refused | input | 1 | Request refused because its block is locked |
| q_count | input | QW | Command queue occupancy |
| buf_avail | input | 1 | Sector buffer available |
| blk_lock | input | NBLK | Lock bit of each block |
| blk_sel | input | BW | Block shown in `bsr` |
| cmd_stb | input | 1 | Configuration command strobe |
| cmd_op | input | 3 | Configuration command code |
| ry_by | output | 1 | Ready/busy pin (low = busy or pulse) |
| csr | output | 8 | Compatible status byte |
| gsr | output | 8 | Global status byte |
| bsr | output | 8 | Block status byte |

## Verification
Two events can fall in the same cycle, and each pair needs an order. The first pair is a clear-status command and a refusal. The bench issues both in one cycle and expects the refusal flag to stay set while the erase-failure flag goes to 0. The second pair is a mode command and a completion that would trigger a pulse. The bench reselects pulse-on-write on the same edge as a write completion and expects the pin to stay high. A start and a done in one cycle are also driven together, and `csr` bit 7 must read busy afterwards.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    PIN_LEVEL  = 2'd0,
    PIN_PWRITE = 2'd1,
    PIN_PERASE = 2'd2,
    PIN_OFF    = 2'd3
  } pin_mode_e;

  localparam logic [2:0] CMD_CLEAR = 3'd4;

  // codes 0..3 pick a pin mode
  function automatic logic is_mode_cmd(input logic [2:0] op);
    return (op[2] == 1'b0);
  endfunction

  function automatic pin_mode_e cmd_to_mode(input logic [2:0] op);
    return pin_mode_e'(op[1:0]);
  endfunction

  function automatic logic [7:0] pack_csr(input logic idle, input logic efail,
                                          input logic wfail, input logic lockerr);
    return {idle, 1'b0, efail, wfail, 2'b00, lockerr, 1'b0};
  endfunction

  function automatic logic [7:0] pack_gsr(input logic idle, input logic qfull,
                                          input logic qbusy, input logic bufav,
                                          input logic anyerr, input logic [1:0] mode);
    return {idle, qfull, qbusy, 1'b0, bufav, anyerr, mode};
  endfunction

  function automatic logic [7:0] pack_bsr(input logic idle, input logic lock,
                                          input logic fail);
    return {idle, lock, fail, 5'b00000};
  endfunction

endpackage

// File: rtl/rbs_state.sv
module rbs_state #(
  parameter int NBLK = 32,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic            op_done,
  input  logic            op_erase,
  input  logic            op_fail,
  input  logic [BW-1:0]   op_blk,
  input  logic            refuse,
  input  logic            clr,
  output logic            busy,
  output logic            wfail,
  output logic            efail,
  output logic            lockerr,
  output logic [NBLK-1:0] blk_fail
);

  logic wfail_set, efail_set;
  assign wfail_set = op_done && op_fail && !op_erase;
  assign efail_set = op_done && op_fail && op_erase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy <= 1'b0;
    else if (op_start) busy <= 1'b1;
    else if (op_done)  busy <= 1'b0;
  end

  // set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wfail   <= 1'b0;
      efail   <= 1'b0;
      lockerr <= 1'b0;
    end else begin
      wfail   <= wfail_set | (wfail & ~clr);
      efail   <= efail_set | (efail & ~clr);
      lockerr <= refuse    | (lockerr & ~clr);
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic hit;
    assign hit = op_done && op_fail && (op_blk == BW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk_fail[g] <= 1'b0;
      else        blk_fail[g] <= hit | (blk_fail[g] & ~clr);
    end
  end

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_start) |=> !busy);
  p_refuse_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> lockerr);
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lockerr && !clr) |=> lockerr);
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !refuse) |=> !lockerr);

endmodule

// File: rtl/rbs_pin.sv
module rbs_pin
  import rbs_pkg::*;
#(
  parameter int PULSE_LEN = 4,
  localparam int CW = $clog2(PULSE_LEN + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_cmd,
  input  pin_mode_e new_mode,
  input  logic      op_done,
  input  logic      op_erase,
  input  logic      engine_active,
  output pin_mode_e mode,
  output logic      pulse_fire,
  output logic      ry_by
);

  logic [CW-1:0] cnt;

  assign pulse_fire = op_done && !mode_cmd &&
                      (((mode == PIN_PWRITE) && !op_erase) ||
                       ((mode == PIN_PERASE) &&  op_erase));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode <= PIN_LEVEL;
    else if (mode_cmd) mode <= new_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (mode_cmd)      cnt <= '0;
    else if (pulse_fire)    cnt <= CW'(PULSE_LEN);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  always_comb begin
    unique case (mode)
      PIN_LEVEL: ry_by = !engine_active;
      PIN_OFF:   ry_by = 1'b1;
      default:   ry_by = (cnt == '0);
    endcase
  end

  p_off_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PIN_OFF) |-> ry_by);
  p_wpulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_fire && !op_erase) |=> !ry_by);
  p_epulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_fire && op_erase) |=> !ry_by);
  p_mode_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cmd |=> (mode == $past(new_mode)));
  p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd && (new_mode != PIN_LEVEL)) |=> ry_by);

endmodule

// File: rtl/rb_status.sv
module rb_status
  import rbs_pkg::*;
#(
  parameter int NBLK      = 32,
  parameter int QDEPTH    = 3,
  parameter int PULSE_LEN = 4,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int QW = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic            op_done,
  input  logic            op_erase,
  input  logic            op_fail,
  input  logic [BW-1:0]   op_blk,
  input  logic            lock_refused,
  input  logic [QW-1:0]   q_count,
  input  logic            buf_avail,
  input  logic [NBLK-1:0] blk_lock,
  input  logic [BW-1:0]   blk_sel,
  input  logic            cmd_stb,
  input  logic [2:0]      cmd_op,
  output logic            ry_by,
  output logic [7:0]      csr,
  output logic [7:0]      gsr,
  output logic [7:0]      bsr
);

  logic            busy, wfail, efail, lockerr;
  logic [NBLK-1:0] blk_fail;
  logic            clr, mode_cmd, engine_active, pulse_fire;
  logic            q_full, q_busy, sel_ok, sel_lock, sel_fail;
  pin_mode_e       pin_mode;

  assign clr           = cmd_stb && (cmd_op == CMD_CLEAR);
  assign mode_cmd      = cmd_stb && is_mode_cmd(cmd_op);
  assign q_busy        = (q_count != '0);
  assign q_full        = (32'(q_count) >= QDEPTH);
  assign engine_active = busy || q_busy;

  rbs_state #(.NBLK(NBLK)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_done  (op_done),
    .op_erase (op_erase),
    .op_fail  (op_fail),
    .op_blk   (op_blk),
    .refuse   (lock_refused),
    .clr      (clr),
    .busy     (busy),
    .wfail    (wfail),
    .efail    (efail),
    .lockerr  (lockerr),
    .blk_fail (blk_fail)
  );

  rbs_pin #(.PULSE_LEN(PULSE_LEN)) u_pin (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_cmd      (mode_cmd),
    .new_mode      (cmd_to_mode(cmd_op)),
    .op_done       (op_done),
    .op_erase      (op_erase),
    .engine_active (engine_active),
    .mode          (pin_mode),
    .pulse_fire    (pulse_fire),
    .ry_by         (ry_by)
  );

  assign sel_ok   = (32'(blk_sel) < NBLK);
  assign sel_lock = sel_ok && blk_lock[blk_sel];
  assign sel_fail = sel_ok && blk_fail[blk_sel];

  assign csr = pack_csr(!busy, efail, wfail, lockerr);
  assign gsr = pack_gsr(!busy, q_full, q_busy, buf_avail,
                        wfail | efail | lockerr, pin_mode);
  assign bsr = pack_bsr(!busy, sel_lock, sel_fail);

  p_level_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_mode == PIN_LEVEL) && engine_active) |-> !ry_by);
  p_level_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_mode == PIN_LEVEL) && !busy && !q_busy) |-> ry_by);
  p_pulse_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_fire |-> (pin_mode == PIN_PWRITE || pin_mode == PIN_PERASE));

endmodule

// File: tb/rb_status_test.sv
module rb_status_test;
  localparam int NBLK = 32, QDEPTH = 3, PULSE_LEN = 4;
  localparam int BW = 5, QW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_start = 0, op_done = 0, op_erase = 0, op_fail = 0, lock_refused = 0;
  logic buf_avail = 0, cmd_stb = 0;
  logic [BW-1:0] op_blk = 5'd3, blk_sel = 5'd3;
  logic [QW-1:0] q_count = '0;
  logic [NBLK-1:0] blk_lock = '0;
  logic [2:0] cmd_op = 3'd0;
  logic ry_by;
  logic [7:0] csr, gsr, bsr;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rb_status #(.NBLK(NBLK), .QDEPTH(QDEPTH), .PULSE_LEN(PULSE_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
    .op_erase(op_erase), .op_fail(op_fail), .op_blk(op_blk),
    .lock_refused(lock_refused), .q_count(q_count), .buf_avail(buf_avail),
    .blk_lock(blk_lock), .blk_sel(blk_sel), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .ry_by(ry_by), .csr(csr), .gsr(gsr), .bsr(bsr));

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {req, start, done, erase, fail, refuse, stb, op, q, exp_ry, exp_csr}
  localparam int NV = 29;
  localparam logic [23:0] VEC [NV] = '{
    {4'd10, 4'b0000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h80}, // R10 idle after reset
    {4'd11, 4'b1000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h00}, // R11 start
    {4'd1,  4'b0000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h00}, // R1 busy low
    {4'd11, 4'b0100, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h80}, // R11 done
    {4'd1,  4'b0000, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0, 8'h80}, // R1 queue low
    {4'd5,  4'b0000, 1'b0, 1'b1, 3'd1, 2'd0, 1'b1, 8'h80}, // R5 pick pulse-write
    {4'd2,  4'b1000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h00}, // R2 busy, no level
    {4'd2,  4'b0100, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h80}, // R2 pulse 1
    {4'd2,  4'b0000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h80}, // R2 pulse 2
    {4'd2,  4'b0000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h80}, // R2 pulse 3
    {4'd2,  4'b0000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h80}, // R2 pulse 4
    {4'd2,  4'b0000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h80}, // R2 pulse ends
    {4'd2,  4'b1000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h00}, // R2 start
    {4'd2,  4'b0111, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'hA0}, // R2 erase no pulse, R6 efail
    {4'd7,  4'b0000, 1'b1, 1'b0, 3'd0, 2'd0, 1'b1, 8'hA2}, // R7 refusal
    {4'd7,  4'b0000, 1'b1, 1'b1, 3'd4, 2'd0, 1'b1, 8'h82}, // R7 clear+refuse
    {4'd7,  4'b0000, 1'b0, 1'b1, 3'd4, 2'd0, 1'b1, 8'h80}, // R7 clear
    {4'd5,  4'b0000, 1'b0, 1'b1, 3'd2, 2'd0, 1'b1, 8'h80}, // R5 pick pulse-erase
    {4'd3,  4'b1000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h00}, // R3 start
    {4'd3,  4'b0110, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h80}, // R3 erase pulse
    {4'd5,  4'b0000, 1'b0, 1'b1, 3'd3, 2'd0, 1'b1, 8'h80}, // R5 off cancels pulse
    {4'd4,  4'b0000, 1'b0, 1'b0, 3'd0, 2'd3, 1'b1, 8'h80}, // R4 off ignores queue
    {4'd5,  4'b0000, 1'b0, 1'b1, 3'd0, 2'd3, 1'b0, 8'h80}, // R5 back to level
    {4'd5,  4'b0000, 1'b0, 1'b1, 3'd6, 2'd0, 1'b1, 8'h80}, // R5 code 6 ignored
    {4'd5,  4'b1000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h00}, // R5 still level
    {4'd6,  4'b0101, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h90}, // R6 write failure
    {4'd5,  4'b0000, 1'b0, 1'b1, 3'd1, 2'd0, 1'b1, 8'h90}, // R5 pulse-write
    {4'd5,  4'b1000, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h10}, // R5 start
    {4'd5,  4'b0100, 1'b0, 1'b1, 3'd1, 2'd0, 1'b1, 8'h90}  // R5 cmd suppresses pulse
  };

  task automatic idle_inputs();
    op_start = 0; op_done = 0; op_erase = 0; op_fail = 0;
    lock_refused = 0; cmd_stb = 0; cmd_op = 3'd0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op_start, op_done, op_erase, op_fail} = VEC[i][19:16];
      lock_refused = VEC[i][15];
      cmd_stb      = VEC[i][14];
      cmd_op       = VEC[i][13:11];
      q_count      = VEC[i][10:9];
      tick();
      chk($sformatf("R%0d", VEC[i][23:20]), $sformatf("vec%0d ry_by", i),
          {7'd0, ry_by}, {7'd0, VEC[i][8]});
      chk($sformatf("R%0d", VEC[i][23:20]), $sformatf("vec%0d csr", i),
          csr, VEC[i][7:0]);
    end

    // R8 global byte: mode is pulse-write, write failure flag set
    @(negedge clk); idle_inputs(); q_count = 2'd3; buf_avail = 1'b1;
    #1 chk("R8", "gsr full", gsr, 8'hED);
    q_count = 2'd1;
    #1 chk("R8", "gsr partial", gsr, 8'hAD);
    buf_avail = 1'b0;
    #1 chk("R8", "gsr no buffer", gsr, 8'hA5);
    q_count = 2'd0;

    // R9 block byte: block 3 failed and is locked
    blk_lock = 32'h0000_0008; blk_sel = 5'd3;
    #1 chk("R9", "bsr blk3", bsr, 8'hE0);
    blk_sel = 5'd4;
    #1 chk("R9", "bsr blk4", bsr, 8'h80);
    blk_sel = 5'd3;

    // R2 retrigger during pulse
    @(negedge clk); op_done = 1; tick();
    chk("R2", "retrig edge1", {7'd0, ry_by}, 8'd0);
    @(negedge clk); op_done = 0; tick();
    @(negedge clk); op_done = 1; tick();
    @(negedge clk); op_done = 0; tick();
    @(negedge clk); tick();
    chk("R2", "retrig still low", {7'd0, ry_by}, 8'd0);
    @(negedge clk); tick();
    @(negedge clk); tick();
    chk("R2", "retrig ended", {7'd0, ry_by}, 8'd1);

    // R11 start and done together keep busy
    @(negedge clk); op_start = 1; op_done = 1; tick();
    chk("R11", "start+done busy", csr, 8'h10);
    @(negedge clk); op_start = 0; op_done = 1; tick();
    chk("R11", "done idle", csr, 8'h90);

    // R10 reset mid-pulse
    @(negedge clk); op_done = 1; tick();
    @(negedge clk); op_done = 0; rst_n = 1'b0;
    #1;
    chk("R10", "reset ry_by", {7'd0, ry_by}, 8'd1);
    chk("R10", "reset csr", csr, 8'h80);
    chk("R10", "reset gsr", gsr, 8'h80);
    chk("R10", "reset bsr", bsr, 8'hC0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); op_start = 1; tick();
    chk("R10", "level mode after reset", {7'd0, ry_by}, 8'd0);
    @(negedge clk); idle_inputs();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule